// File: doc/BRIEF.md
# Two-Lane Packed Float/Integer Converter

This block converts packed operands between signed integers and a single-precision float format. Each 64-bit operand carries two independent 32-bit lanes. A single function code applies the same conversion to both lanes in the same cycle. The unit raises no exceptions and reports no status. Every conversion truncates toward zero. Integer results that fall outside the target range saturate without any signal.

Floats use a sign in bit 31, an 8-bit exponent in bits 30:23 biased by 127, and a 23-bit fraction in bits 22:0 below a hidden leading one. This gives significands in [1,2). An exponent field of 00h means zero whatever the fraction holds. An exponent field of FFh is outside the supported range, and the result for it is undefined.

Operands enter on a valid/ready stream and results leave on another. One register stage sits between them, so a result appears one clock after its operand is accepted. The input accepts a new operand whenever the output register is empty or is being drained in the same cycle. While the consumer holds `res_ready` low and a result is waiting, `op_ready` stays low and the waiting result does not change.

Top module: `pk_cvt_unit`

## Requirements
- R1: Both 32-bit lanes, bits 31:0 and bits 63:32, are converted in the same cycle by the same function. Neither lane affects the other.
- R2: Function code 8'h1D converts a float lane to a signed 32-bit integer, truncating toward zero. For example, -2.75 gives FFFFFFFEh and 0.9 gives 0.
- R3: Under function 8'h1D, a value at or above 2^31 saturates to 7FFFFFFFh, and a value at or below -2^31 gives 80000000h.
- R4: Under functions 8'h1D and 8'h1C, a float lane whose exponent field is 00h gives integer 0, whatever its fraction bits hold.
- R5: Function code 8'h1C converts a float lane to a signed 16-bit integer, truncating toward zero. The result saturates to the range -32768..32767 and is sign-extended into all 32 bits of the lane.
- R6: Function code 8'h0D converts a signed 32-bit lane to float. Significant bits below the top 24 are dropped (truncation), and integer 0 gives 00000000h.
- R7: Function code 8'h0C converts bits 15:0 of each lane, read as a signed value, to float. Bits 31:16 of the lane are ignored.
- R8: Every function code other than the four above gives 0 in both lanes.
- R9: After reset `res_valid` is 0. An operand accepted on a clock edge (`op_valid` and `op_ready` both high) produces `res_valid` high with its result after that same edge.
- R10: While `res_valid` is high and `res_ready` is low, `op_ready` is low and `res_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operand and function are valid |
| op_ready | output | 1 | Unit can accept an operand this cycle |
| op_func | input | 8 | Conversion function code |
| op_data | input | 64 | Packed operand, two 32-bit lanes |
| res_valid | output | 1 | Result register holds a result |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_data | output | 64 | Packed result, two 32-bit lanes |

## Verification
The assertions assume that the consumer follows the stream rules, and that `op_func` and `op_data` are known whenever `op_valid` is high. They also assume that no float lane fed to a float-to-integer function has exponent FFh, because that result is not defined. The stimulus clears bit 30 of any random float lane whose exponent comes out as FFh. Only `res_ready` is driven with random back-pressure, and it changes just after a clock edge, so every handshake is decided on stable signals.

// File: rtl/pk_cvt_pkg.sv
package pk_cvt_pkg;
  localparam int LANE_W  = 32;
  localparam int N_LANES = 2;
  localparam int OP_W    = LANE_W * N_LANES;
  localparam int FN_W    = 8;

  typedef enum logic [FN_W-1:0] {
    FN_F2D = 8'h1D,
    FN_I2D = 8'h0D,
    FN_F2W = 8'h1C,
    FN_I2W = 8'h0C
  } cvt_fn_e;
endpackage

// File: rtl/pk_cvt_f2i.sv
module pk_cvt_f2i #(
  parameter int LANE_W = 32,
  parameter int OUT_W  = 32
) (
  input  logic [LANE_W-1:0] f_in,
  output logic [LANE_W-1:0] i_out
);
  localparam int FRAC_W = 23;
  localparam int BIAS   = 127;
  localparam logic [LANE_W-1:0] POS_SAT = LANE_W'((64'd1 << (OUT_W - 1)) - 64'd1);
  localparam logic [LANE_W-1:0] NEG_SAT = ~POS_SAT;

  logic              sgn;
  logic [7:0]        bexp;
  logic [FRAC_W:0]   sig;
  logic [LANE_W-1:0] mag;
  int                uexp;

  assign sgn  = f_in[31];
  assign bexp = f_in[30:23];
  assign sig  = {1'b1, f_in[FRAC_W-1:0]};

  always_comb begin
    uexp  = int'(bexp) - BIAS;
    mag   = '0;
    i_out = '0;
    if (bexp == 8'h00 || uexp < 0) begin
      i_out = '0;
    end else if (uexp >= OUT_W - 1) begin
      i_out = sgn ? NEG_SAT : POS_SAT;
    end else begin
      if (uexp <= FRAC_W) mag = LANE_W'(sig) >> (FRAC_W - uexp);
      else                mag = LANE_W'(sig) << (uexp - FRAC_W);
      i_out = sgn ? (~mag + 1'b1) : mag;
    end
  end
endmodule

// File: rtl/pk_cvt_i2f.sv
module pk_cvt_i2f #(
  parameter int LANE_W = 32
) (
  input  logic [LANE_W-1:0] i_in,
  output logic [LANE_W-1:0] f_out
);
  localparam int FRAC_W = 23;
  localparam int POS_W  = $clog2(LANE_W);

  logic              sgn;
  logic [LANE_W-1:0] mag;
  logic [LANE_W-1:0] aligned;
  logic [POS_W-1:0]  msb;
  logic [7:0]        bexp;

  assign sgn = i_in[LANE_W-1];
  assign mag = sgn ? (~i_in + 1'b1) : i_in;

  always_comb begin
    msb = '0;
    for (int i = 0; i < LANE_W; i++) begin
      if (mag[i]) msb = POS_W'(i);
    end
  end

  always_comb begin
    if (int'(msb) >= FRAC_W) aligned = mag >> (int'(msb) - FRAC_W);
    else                     aligned = mag << (FRAC_W - int'(msb));
    bexp = 8'(127 + int'(msb));
    if (i_in == '0) f_out = '0;
    else            f_out = {sgn, bexp, aligned[FRAC_W-1:0]};
  end
endmodule

// File: rtl/pk_cvt_lane.sv
module pk_cvt_lane
  import pk_cvt_pkg::*;
#(
  parameter int W = LANE_W
) (
  input  logic [FN_W-1:0] func,
  input  logic [W-1:0]    a,
  output logic [W-1:0]    y
);
  localparam int HALF = 16;

  logic [W-1:0] f2d_q, f2w_q, i2f_q, i2f_src;

  pk_cvt_f2i #(.LANE_W(W), .OUT_W(W))    u_f2d (.f_in(a), .i_out(f2d_q));
  pk_cvt_f2i #(.LANE_W(W), .OUT_W(HALF)) u_f2w (.f_in(a), .i_out(f2w_q));

  assign i2f_src = (func == FN_I2W) ? {{(W-HALF){a[HALF-1]}}, a[HALF-1:0]} : a;

  pk_cvt_i2f #(.LANE_W(W)) u_i2f (.i_in(i2f_src), .f_out(i2f_q));

  always_comb begin
    case (func)
      FN_F2D:         y = f2d_q;
      FN_F2W:         y = f2w_q;
      FN_I2D, FN_I2W: y = i2f_q;
      default:        y = '0;
    endcase
  end
endmodule

// File: rtl/pk_cvt_unit.sv
module pk_cvt_unit
  import pk_cvt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic [FN_W-1:0] op_func,
  input  logic [OP_W-1:0] op_data,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [OP_W-1:0] res_data
);
  logic [OP_W-1:0] lanes_y;
  logic            take;

  genvar g;
  generate
    for (g = 0; g < N_LANES; g++) begin : g_lane
      pk_cvt_lane #(.W(LANE_W)) u_lane (
        .func (op_func),
        .a    (op_data[g*LANE_W +: LANE_W]),
        .y    (lanes_y[g*LANE_W +: LANE_W])
      );
    end
  endgenerate

  assign op_ready = !res_valid || res_ready;
  assign take     = op_valid && op_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else if (take) begin
      res_valid <= 1'b1;
      res_data  <= lanes_y;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  assert_accept_gives_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> res_valid);

  assert_stall_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  assert_stall_blocks_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !op_ready);

  assert_word_sign_extended_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op_func == FN_F2W) |=>
      (res_data[31:16] == {16{res_data[15]}} && res_data[63:48] == {16{res_data[47]}}));

  assert_zero_exponent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op_func == FN_F2D && op_data[30:23] == 8'h00) |=> res_data[31:0] == '0);

  assert_int_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op_func == FN_I2D && op_data[63:32] == '0) |=> res_data[63:32] == '0);

  assert_unknown_func_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !(op_func inside {FN_F2D, FN_F2W, FN_I2D, FN_I2W})) |=> res_data == '0);
endmodule

// File: tb/tb_pk_cvt_unit.sv
`timescale 1ns/1ps
module tb_pk_cvt_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic        op_ready;
  logic [7:0]  op_func;
  logic [63:0] op_data;
  logic        res_valid;
  logic        res_ready;
  logic [63:0] res_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  bit          bp_en = 1'b0;
  bit          ready_force = 1'b1;
  logic [15:0] lfsr = 16'hACE1;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  pk_cvt_unit dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_func(op_func), .op_data(op_data), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // reference model: float lane to signed integer of w bits, sign-extended
  function automatic logic [31:0] m_f2i(input logic [31:0] f, input int w);
    longint lim, mag, v;
    int ue;
    if (f[30:23] == 8'h00) return 32'h0;
    ue = int'(f[30:23]) - 127;
    if (ue < 0) return 32'h0;
    lim = longint'(1) << (w - 1);
    if (ue > 40) mag = lim * 2;
    else mag = (longint'({1'b1, f[22:0]}) << ue) >> 23;
    v = f[31] ? -mag : mag;
    if (v > lim - 1) v = lim - 1;
    if (v < -lim) v = -lim;
    return v[31:0];
  endfunction

  function automatic logic [31:0] m_i2f(input logic [31:0] x);
    longint mag, t;
    int p;
    if (x == 32'h0) return 32'h0;
    mag = x[31] ? -longint'($signed(x)) : longint'(x);
    p = 31;
    while (mag[p] == 1'b0) p--;
    t = mag << (40 - p);
    return {x[31], 8'(127 + p), t[39:17]};
  endfunction

  function automatic logic [31:0] m_lane(input logic [7:0] fn, input logic [31:0] a);
    case (fn)
      8'h1D: return m_f2i(a, 32);
      8'h1C: return m_f2i(a, 16);
      8'h0D: return m_i2f(a);
      8'h0C: return m_i2f({{16{a[15]}}, a[15:0]});
      default: return 32'h0;
    endcase
  endfunction

  task automatic send(input logic [7:0] fn, input logic [63:0] a, input string tag);
    @(negedge clk);
    op_valid = 1'b1;
    op_func  = fn;
    op_data  = a;
    while (!op_ready) @(negedge clk);
    @(posedge clk);
    exp_q.push_back({m_lane(fn, a[63:32]), m_lane(fn, a[31:0])});
    tag_q.push_back(tag);
    #1;
    check(res_valid === 1'b1, "R9 latency", {63'b0, res_valid}, 64'd1);
  endtask

  task automatic idle();
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    res_ready <= bp_en ? (lfsr[0] | lfsr[3]) : ready_force;
  end

  // monitor: compare every result that leaves the unit
  always @(negedge clk) begin
    if (rst_n === 1'b1 && res_valid && res_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected result", res_data, 64'h0);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(res_data === e, t, res_data, e);
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] snap;
    rst_n = 1'b0; op_valid = 1'b0; op_func = 8'h0; op_data = '0; res_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(res_valid === 1'b0, "R9 reset", {63'b0, res_valid}, 64'd0);
    rst_n = 1'b1;

    // R2 truncation; R1 distinct lanes
    send(8'h1D, {32'hC0300000, 32'h3FC00000}, "R2 -2.75/1.5");
    send(8'h1D, {32'h47F12064, 32'h3F666666}, "R2 123456.78/0.9");
    send(8'h1D, {32'h4E800000, 32'hBF800000}, "R1 2^30/-1");
    // R3 saturation
    send(8'h1D, {32'hCF32D05E, 32'h501502F9}, "R3 -3e9/1e10");
    send(8'h1D, {32'hCF000000, 32'h4F000000}, "R3 -2^31/2^31");
    // R4 zero exponent
    send(8'h1D, {32'h807FFFFF, 32'h00400000}, "R4 f2d exp0");
    send(8'h1C, {32'h00000001, 32'h80400000}, "R4 f2w exp0");
    // R5 word
    send(8'h1C, {32'hC71C4000, 32'h471C4000}, "R5 +-40000");
    send(8'h1C, {32'hC2C90000, 32'h46FFFE00}, "R5 -100.5/32767");
    send(8'h1C, {32'hC7000000, 32'hC7000100}, "R5 -32768/-32769");
    // R6 dword to float
    send(8'h0D, {32'h00000000, 32'h00000001}, "R6 0/1");
    send(8'h0D, {32'hFFFFFFFF, 32'h01000001}, "R6 -1/2^24+1");
    send(8'h0D, {32'h80000000, 32'h7FFFFFFF}, "R6 extremes");
    // R7 word to float, upper bits ignored
    send(8'h0C, {32'hABCD0005, 32'h0000FFFF}, "R7 5/-1");
    send(8'h0C, {32'h12348000, 32'hFFFF7FFF}, "R7 -32768/32767");
    // R8 unknown codes
    send(8'h00, {32'h3F800000, 32'h00000005}, "R8 code 00");
    send(8'h1E, {32'h3F800000, 32'h00000005}, "R8 code 1E");
    idle();
    repeat (4) @(negedge clk);

    // R10 stall
    ready_force = 1'b0;
    @(posedge clk);
    send(8'h0D, {32'd7, 32'd9}, "R10 stalled item");
    idle();
    @(negedge clk);
    snap = res_data;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(res_valid === 1'b1 && op_ready === 1'b0 && res_data === snap,
            "R10 hold", res_data, snap);
    end
    ready_force = 1'b1;
    repeat (4) @(negedge clk);

    // R1 random mix with back-pressure
    bp_en = 1'b1;
    for (int k = 0; k < 300; k++) begin
      logic [63:0] a;
      logic [7:0] fn;
      int sel;
      a = {$urandom, $urandom};
      if (a[30:23] == 8'hFF) a[30] = 1'b0;
      if (a[62:55] == 8'hFF) a[62] = 1'b0;
      sel = $urandom_range(0, 4);
      fn = (sel == 0) ? 8'h1D : (sel == 1) ? 8'h1C : (sel == 2) ? 8'h0D :
           (sel == 3) ? 8'h0C : 8'h55;
      send(fn, a, "R1 random");
    end
    idle();
    bp_en = 1'b0;
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R9 drain", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule